// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Detection

A word-addressed controller for up to 32 general-purpose pins on a plain 32-bit register bus. Software sets each pin's direction and output level, reads the pins back, and arms a per-pin interrupt detector. Each detector watches the synchronised pin level and can be set to level-high, level-low, rising edge, falling edge or both edges. Detected conditions gather in a status register. A pending view masks them with the enables, and one interrupt line is the OR of all pending bits.

Pin inputs pass through two flops before any use. A third flop holds the previous synchronised value for edge detection. Edge events latch until software writes a one to the matching bit of the acknowledge register. Level conditions carry no memory and simply track the pin. Reads are registered: `bus_rdata` takes the selected register one clock after `bus_re` and holds it otherwise.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all zero, direction register reads ones in the NPINS low bits), the enable register reads 0 and `irq` is low.
- R2: Direction register (offset 0x04): bit value 1 = input, 0 = output. `pin_oe[i]` is high exactly when pin i is an output. `pin_out` carries the output register (offset 0x00 write), masked to NPINS bits.
- R3: Reading offset 0x00 returns the synchronised pad level for input pins and the output register bit for output pins. Bits at NPINS and above read 0 in every register.
- R4: With the edge-select bit (offset 0x18) at 0, a pin's status bit (offset 0x0C) follows its synchronised level. Polarity (offset 0x1C) 1 means active-high, 0 means active-low. An acknowledge write does not keep it low while the level stays active.
- R5: With the edge-select bit at 1 and the both-edges bit (offset 0x24) at 0, polarity 1 latches status on a rising transition and polarity 0 on a falling one. The bit stays set after the pin returns.
- R6: With edge-select and both-edges both at 1, either transition latches status and polarity is ignored. A both-edges bit with edge-select at 0 leaves the pin in level mode.
- R7: Writing 1 to a bit of the acknowledge register (offset 0x14) clears a latched edge status bit, and writing 0 leaves it unchanged. An edge event in the same cycle as the clear wins.
- R8: The pending register (offset 0x10) reads status AND enable (offset 0x08). `irq` is high exactly when any pending bit is set.
- R9: Offset 0x20 reads the constant 3. Writes to offsets 0x20, 0x0C and 0x10 change no register.
- R10: `bus_rdata` loads the addressed register on the clock edge where `bus_re` is high and holds its value on every other edge.
- R11: An edge on `pin_in` driven between clock edges shows as status (and `irq`, if enabled) after the third following rising clock edge, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Levels to drive on output pins |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong synchroniser depth or a missing previous-value flop moves a status change off the third edge, or drops edges, and this shows on `irq` within one or two cycles of the expected edge. A bad mode decode latches level pins or lets a level pin forget. The interrupt line then disagrees with the reference model on the first cycle after the pin returns, or after an acknowledge. Corrupted configuration or read-mux state shows at `bus_rdata` one cycle after the next read. It shows at once on `pin_oe` and `pin_out`, since these are compared on every clock.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;
  localparam logic [BUS_AW-1:0] OFS_LEVEL  = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_DIR    = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_ENABLE = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_STATUS = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_PEND   = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_ACK    = 8'h14;
  localparam logic [BUS_AW-1:0] OFS_EDGE   = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_POL    = 8'h1C;
  localparam logic [BUS_AW-1:0] OFS_REV    = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_DUAL   = 8'h24;
  localparam logic [BUS_DW-1:0] HW_REVISION = 32'd3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = d;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign lvl      = sync_q;
  assign lvl_prev = prev_q;
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] lvl_prev,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] both,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat
);
  logic [W-1:0] stat_q, stat_d, ev_w;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise_w, fall_w, active_w;
    always_comb begin
      rise_w   = lvl[i] & ~lvl_prev[i];
      fall_w   = ~lvl[i] & lvl_prev[i];
      active_w = pol[i] ? lvl[i] : ~lvl[i];
      if (both[i])     ev_w[i] = rise_w | fall_w;
      else if (pol[i]) ev_w[i] = rise_w;
      else             ev_w[i] = fall_w;
      if (edge_sel[i]) stat_d[i] = (stat_q[i] & ~clr[i]) | ev_w[i];
      else             stat_d[i] = active_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;

  // R4
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(edge_sel)) ==
              (~($past(pol) ^ $past(lvl)) & ~$past(edge_sel))));
  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat & edge_sel & ~clr) & ~stat) == '0));
  // R6
  dual_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_sel & both & (lvl ^ lvl_prev)) & ~stat) == '0));
  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(edge_sel & clr & ~ev_w)) == '0));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ctrl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] addr,
  input  logic              we,
  input  logic [BUS_DW-1:0] wdata,
  input  logic              re,
  output logic [BUS_DW-1:0] rdata,
  input  logic [W-1:0]      lvl,
  input  logic [W-1:0]      stat,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      outv,
  output logic [W-1:0]      en,
  output logic [W-1:0]      edge_sel,
  output logic [W-1:0]      pol,
  output logic [W-1:0]      both,
  output logic [W-1:0]      clr
);
  logic [W-1:0] dir_q, out_q, en_q, edge_q, pol_q, both_q;
  logic [W-1:0] wr_val;
  logic wr_out, wr_dir, wr_en, wr_edge, wr_pol, wr_both, wr_ack;
  logic [BUS_DW-1:0] rdata_q, rdata_d, mux_w;

  function automatic logic [BUS_DW-1:0] widen(input logic [W-1:0] v);
    logic [BUS_DW-1:0] r;
    r = '0;
    r[W-1:0] = v;
    return r;
  endfunction

  always_comb begin
    wr_val  = wdata[W-1:0];
    wr_out  = we && (addr == OFS_LEVEL);
    wr_dir  = we && (addr == OFS_DIR);
    wr_en   = we && (addr == OFS_ENABLE);
    wr_ack  = we && (addr == OFS_ACK);
    wr_edge = we && (addr == OFS_EDGE);
    wr_pol  = we && (addr == OFS_POL);
    wr_both = we && (addr == OFS_DUAL);
    clr     = wr_ack ? wr_val : '0;
  end

  always_comb begin
    case (addr)
      OFS_LEVEL:  mux_w = widen((dir_q & lvl) | (~dir_q & out_q));
      OFS_DIR:    mux_w = widen(dir_q);
      OFS_ENABLE: mux_w = widen(en_q);
      OFS_STATUS: mux_w = widen(stat);
      OFS_PEND:   mux_w = widen(stat & en_q);
      OFS_EDGE:   mux_w = widen(edge_q);
      OFS_POL:    mux_w = widen(pol_q);
      OFS_REV:    mux_w = HW_REVISION;
      OFS_DUAL:   mux_w = widen(both_q);
      default:    mux_w = '0;
    endcase
    rdata_d = re ? mux_w : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      out_q   <= '0;
      en_q    <= '0;
      edge_q  <= '0;
      pol_q   <= '0;
      both_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= wr_val;
      if (wr_out)  out_q  <= wr_val;
      if (wr_en)   en_q   <= wr_val;
      if (wr_edge) edge_q <= wr_val;
      if (wr_pol)  pol_q  <= wr_val;
      if (wr_both) both_q <= wr_val;
      rdata_q <= rdata_d;
    end
  end

  assign dir      = dir_q;
  assign outv     = out_q;
  assign en       = en_q;
  assign edge_sel = edge_q;
  assign pol      = pol_q;
  assign both     = both_q;
  assign rdata    = rdata_q;

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] lvl_w, prev_w, stat_w;
  logic [NPINS-1:0] dir_w, out_w, en_w, edge_w, pol_w, both_w, clr_w;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .lvl(lvl_w), .lvl_prev(prev_w)
  );

  gpio_trig #(.W(NPINS)) u_trig (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_w), .lvl_prev(prev_w),
    .edge_sel(edge_w), .pol(pol_w), .both(both_w), .clr(clr_w), .stat(stat_w)
  );

  gpio_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .re(bus_re), .rdata(bus_rdata), .lvl(lvl_w), .stat(stat_w),
    .dir(dir_w), .outv(out_w), .en(en_w), .edge_sel(edge_w), .pol(pol_w),
    .both(both_w), .clr(clr_w)
  );

  assign pin_out = out_w;
  assign pin_oe  = ~dir_w;
  assign irq     = |(stat_w & en_w);

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w == '0) |-> !irq);
  // R1
  reset_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0));
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int  NP    = 24;
  localparam time TCLK  = 10ns;
  localparam logic [31:0] MASK = 32'h00FF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  bit live = 0;

  always #(TCLK/2) clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference
  logic [31:0] m_dir, m_out, m_en, m_edge, m_pol, m_both, m_stat, m_rd;
  logic [31:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = MASK; m_out = 0; m_en = 0; m_edge = 0; m_pol = 0; m_both = 0;
      m_stat = 0; m_rd = 0;
      hist = '{32'd0, 32'd0, 32'd0};
    end else begin
      logic [31:0] now_l, old_l, ack, wv, nstat;
      now_l = hist[1]; old_l = hist[2];
      wv  = bus_wdata & MASK;
      ack = (bus_we && bus_addr == 8'h14) ? wv : 0;
      nstat = 0;
      for (int i = 0; i < NP; i++) begin
        bit ev;
        if (m_both[i])     ev = now_l[i] != old_l[i];
        else if (m_pol[i]) ev = now_l[i] && !old_l[i];
        else               ev = !now_l[i] && old_l[i];
        if (m_edge[i]) nstat[i] = (m_stat[i] && !ack[i]) || ev;
        else           nstat[i] = m_pol[i] ? now_l[i] : !now_l[i];
      end
      if (bus_re) begin
        case (bus_addr)
          8'h00: m_rd = ((m_dir & now_l) | (~m_dir & m_out)) & MASK;
          8'h04: m_rd = m_dir;   8'h08: m_rd = m_en;
          8'h0C: m_rd = m_stat;  8'h10: m_rd = m_stat & m_en;
          8'h18: m_rd = m_edge;  8'h1C: m_rd = m_pol;
          8'h20: m_rd = 3;       8'h24: m_rd = m_both;
          default: m_rd = 0;
        endcase
      end
      if (bus_we) begin
        case (bus_addr)
          8'h00: m_out = wv;  8'h04: m_dir = wv;  8'h08: m_en = wv;
          8'h18: m_edge = wv; 8'h1C: m_pol = wv;  8'h24: m_both = wv;
          default: ;
        endcase
      end
      m_stat = nstat;
      hist.push_front(32'(pin_in));
      void'(hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live && rst_n) begin
      check(32'(pin_oe) == (~m_dir & MASK), "R2 pin_oe", 32'(pin_oe), ~m_dir & MASK);
      check(32'(pin_out) == m_out, "R2 pin_out", 32'(pin_out), m_out);
      check(irq == |(m_stat & m_en), "R8 irq", 32'(irq), 32'(|(m_stat & m_en)));
      check(bus_rdata == m_rd, "R10 rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] msk, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_re = 1; bus_addr = a;
    @(negedge clk); bus_re = 0;
    check((bus_rdata & msk) == exp, tag, bus_rdata & msk, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic irq_exp(input bit exp, input string tag);
    check(irq == exp, tag, 32'(irq), 32'(exp));
  endtask

  initial begin
    #(TCLK * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1; live = 1;
    // R1 reset state
    check(pin_oe == '0, "R1 oe", 32'(pin_oe), 0);
    irq_exp(0, "R1 irq");
    rd_exp(8'h04, 32'hFFFF_FFFF, MASK, "R1 dir");
    rd_exp(8'h08, 32'hFFFF_FFFF, 0, "R1 enable");
    rd_exp(8'h20, 32'hFFFF_FFFF, 3, "R9 revision");
    // R2 / R3 direction and levels
    wr(8'h04, 32'hFFFF_FF00);
    wr(8'h00, 32'hFF00_00A5);
    check(pin_oe == 24'h0000FF, "R2 oe", 32'(pin_oe), 32'hFF);
    check(pin_out == 24'h0000A5, "R2 out", 32'(pin_out), 32'hA5);
    rd_exp(8'h04, 32'hFFFF_FFFF, 32'h00FF_FF00, "R3 dir mask");
    pin_in = 24'h12345A;
    idle(3);
    rd_exp(8'h00, 32'hFFFF_FFFF, 32'h0012_34A5, "R3 levels");
    // R9 read-only registers
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_exp(8'h20, 32'hFFFF_FFFF, 3, "R9 revision write");
    pin_in = '0;
    idle(3);
    rd_exp(8'h0C, 32'h0000_FF00, 32'h0000_FF00, "R9 status write");
    // R4 level-high on pin 8
    wr(8'h1C, 32'h0000_0100);
    wr(8'h08, 32'h0000_0100);
    idle(1);
    irq_exp(0, "R4 low inactive");
    pin_in[8] = 1; idle(3);
    irq_exp(1, "R4 high active");
    wr(8'h14, 32'h0000_0100); idle(1);
    irq_exp(1, "R4 reasserts after ack");
    pin_in[8] = 0; idle(3);
    irq_exp(0, "R4 follows level");
    // R4 level-low pin 9 (polarity 0)
    wr(8'h08, 32'h0000_0200); idle(1);
    irq_exp(1, "R4 level low");
    pin_in[9] = 1; idle(3);
    irq_exp(0, "R4 level low released");
    // R5 rising edge on pin 10
    wr(8'h18, 32'h0000_7C00);
    wr(8'h1C, 32'h0000_6400);
    wr(8'h14, 32'h0000_7C00);
    wr(8'h08, 32'h0000_0400); idle(1);
    irq_exp(0, "R5 idle");
    pin_in[10] = 1; idle(1);
    pin_in[10] = 0; idle(4);
    irq_exp(1, "R5 rise latched");
    wr(8'h14, 32'h0000_0000); idle(1);
    irq_exp(1, "R7 zero ack no effect");
    wr(8'h14, 32'h0000_0400); idle(1);
    irq_exp(0, "R7 ack clears");
    // R5 falling edge on pin 11
    wr(8'h08, 32'h0000_0800);
    pin_in[11] = 1; idle(4);
    irq_exp(0, "R5 rise ignored for falling");
    pin_in[11] = 0; idle(4);
    irq_exp(1, "R5 fall latched");
    wr(8'h14, 32'h0000_0800);
    // R6 both edges on pin 12 with polarity 0
    wr(8'h24, 32'h0000_3000);
    wr(8'h1C, 32'h0000_0000);
    wr(8'h08, 32'h0000_1000); idle(1);
    irq_exp(0, "R6 idle");
    pin_in[12] = 1; idle(4);
    irq_exp(1, "R6 rise caught");
    wr(8'h14, 32'h0000_1000); idle(1);
    irq_exp(0, "R6 cleared");
    pin_in[12] = 0; idle(4);
    irq_exp(1, "R6 fall caught");
    wr(8'h14, 32'h0000_1000);
    // R6 both bit without edge bit: pin 16 level-low
    wr(8'h24, 32'h0001_0000);
    wr(8'h1C, 32'h0000_0000);
    wr(8'h08, 32'h0001_0000); idle(1);
    irq_exp(1, "R6 dual without edge is level");
    pin_in[16] = 1; idle(3);
    irq_exp(0, "R6 dual without edge follows");
    // R11 latency on pin 13 rising
    wr(8'h1C, 32'h0000_2000);
    wr(8'h14, 32'h0000_2000);
    wr(8'h08, 32'h0000_2000);
    pin_in[13] = 1; idle(2);
    irq_exp(0, "R11 not after two edges");
    idle(1);
    irq_exp(1, "R11 after third edge");
    // R7 clear coincident with event on pin 13 falling (both-edges)
    wr(8'h24, 32'h0000_2000);
    wr(8'h14, 32'h0000_2000);
    pin_in[13] = 0;
    idle(2);
    bus_we = 1; bus_addr = 8'h14; bus_wdata = 32'h0000_2000;
    idle(1); bus_we = 0;
    irq_exp(1, "R7 event beats ack");
    // R8 pending view and masking
    rd_exp(8'h10, 32'hFFFF_FFFF, 32'h0000_2000, "R8 pending");
    rd_exp(8'h0C, 32'h0000_2000, 32'h0000_2000, "R8 status");
    wr(8'h08, 32'h0000_0000); idle(1);
    irq_exp(0, "R8 masked");
    rd_exp(8'h10, 32'hFFFF_FFFF, 0, "R8 pending masked");
    idle(4);
    live = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule